// File: doc/BRIEF.md
# Interrupt Controller Command Decoder and Setup Sequencer

This block is the register front end of an eight-line interrupt controller. A host writes and reads it through a chip select, single-cycle write and read strobes, a one-bit address and an 8-bit data path. After reset the block accepts nothing until it receives a setup-start word. It then expects a vector-base word. A cascade word follows only when the start word asks for cascading, and a mode word follows only when the start word asks for one. After that the block is ready.

Once ready, writes load the line mask or are decoded as two kinds of command word. One kind ends or rotates service and is passed to the priority logic as a one-cycle command strobe with its fields. The other kind selects which status register a read returns, arms a poll, or sets or clears special mask mode. The priority resolver, the in-service logic and the acknowledge vector output sit outside this block. They take the configuration and strobes from here and supply the request register, the in-service register and the current poll result.

Reads are combinational while the read strobe and chip select are both high. A read with address 1 returns the mask. A read with address 0 returns the selected status register. When a poll is armed, the first read returns a poll word instead, and that read commits the acknowledge one cycle later.

Top module: `pic_cmd_front`

## Requirements
- R1: A chip-selected write with addrSel=0 and wrData[4]=1 is a setup-start word in every state, including partway through setup. It restarts setup: cfgReady goes low and the next addrSel=1 write is taken as the vector-base word.
- R2: A setup-start word clears maskReg, sets cfgCascade to 8'h07, clears specialMask, selects the request register for status reads, cancels an armed poll, and pulses initStb for exactly one cycle.
- R3: The setup-start word fields are: bit0 = mode word follows, bit1 = cfgSingle, bit2 = cfgInterval4, bit3 = cfgLevelTrig, bits7:5 = cfgVecHigh. When bit0 is 0, all five mode-word outputs are cleared.
- R4: Setup order is start word, then vector-base word (cfgVecBase), then cascade word (cfgCascade) only if cfgSingle=0, then mode word only if start bit0=1. cfgReady rises on the write that completes the sequence.
- R5: The mode word fields are: bit0 = cfgCpuMode, bit1 = cfgAutoEoi, bit2 = cfgMaster, bit3 = cfgBuffered, bit4 = cfgNestedSpecial.
- R6: When ready, an addrSel=1 write loads maskReg (a 1 masks the line), and a read with addrSel=1 returns maskReg.
- R7: Before the first start word, addrSel=1 writes and addrSel=0 writes with wrData[4]=0 have no effect. During setup, addrSel=0 writes with wrData[4]=0 have no effect.
- R8: When ready, an addrSel=0 write with wrData[4:3]=00 gives a one-cycle eoiValid pulse with eoiRotate=bit7, eoiSelect=bit6, eoiEnd=bit5 and eoiLevel=bits2:0.
- R9: When ready, an addrSel=0 write with wrData[4:3]=01 is a status word. If bit1=1, bit0 selects the request register (0) or the in-service register (1) for reads. If bit1=0, the selection is kept.
- R10: In the status word, bit6=1 sets specialMask to bit5. If bit6=0, specialMask is unchanged.
- R11: Status word bit2=1 arms a poll. The next chip-selected read returns {pollPending, 4'b0, pollLevel}. In the cycle after that read, pollCommit equals pollPending and pollCommitLevel equals pollLevel. Later reads are normal.
- R12: A read with addrSel=0 returns irrIn or isrIn according to the selection. rdData is 0 when the read strobe or chip select is low, and such a cycle does not consume an armed poll.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| chipSel | input | 1 | Chip select for read and write |
| wrStb | input | 1 | Single-cycle write strobe |
| rdStb | input | 1 | Read strobe |
| addrSel | input | 1 | Register address bit |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data (combinational) |
| irrIn | input | 8 | Request register from the priority logic |
| isrIn | input | 8 | In-service register from the priority logic |
| pollPending | input | 1 | An unmasked request is pending |
| pollLevel | input | 3 | Highest-priority pending level |
| cfgReady | output | 1 | Setup complete |
| cfgSingle | output | 1 | Single device, no cascade |
| cfgInterval4 | output | 1 | Call interval of 4 |
| cfgLevelTrig | output | 1 | Level-triggered requests |
| cfgVecHigh | output | 3 | Vector address bits 7:5 |
| cfgVecBase | output | 8 | Vector-base word |
| cfgCascade | output | 8 | Cascade word (slave map or slave id) |
| cfgCpuMode | output | 1 | Processor mode select |
| cfgAutoEoi | output | 1 | Automatic end of service |
| cfgMaster | output | 1 | Master role in buffered mode |
| cfgBuffered | output | 1 | Buffered mode |
| cfgNestedSpecial | output | 1 | Special fully nested mode |
| maskReg | output | 8 | Line mask |
| specialMask | output | 1 | Special mask mode |
| initStb | output | 1 | One-cycle pulse after a start word |
| eoiValid | output | 1 | One-cycle end/rotate command pulse |
| eoiRotate | output | 1 | Rotate field |
| eoiSelect | output | 1 | Specific-level field |
| eoiEnd | output | 1 | End-of-service field |
| eoiLevel | output | 3 | Level field |
| pollCommit | output | 1 | One-cycle poll acknowledge commit |
| pollCommitLevel | output | 3 | Level committed by the poll |

## Verification
A wrong sequencer state shows on the next setup write. The vector-base or cascade value lands in the wrong output field, or cfgReady rises one word early or late, so the bench checks every field and cfgReady after every setup write. A stale poll or status-select flag shows on the very next read as a wrong rdData byte, and a lost or repeated poll shows as a wrong pollCommit one cycle after that read. Command strobes are checked in the cycle right after the write and again one cycle later, which catches both a missing pulse and a stretched one.

// File: rtl/pic_cmd_pkg.sv
package pic_cmd_pkg;

  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_BASE,
    SEQ_CASC,
    SEQ_MODE,
    SEQ_RDY
  } seqState_t;

  typedef struct packed {
    logic ldStart;
    logic ldBase;
    logic ldCasc;
    logic ldMode;
    logic ldMask;
    logic ldEoi;
    logic ldStat;
    logic rdAcc;
  } cmdStb_t;

endpackage

// File: rtl/pic_seq_ctrl.sv
module pic_seq_ctrl
  import pic_cmd_pkg::*;
#(
  parameter int NUM_LINES = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 chipSel,
  input  logic                 wrStb,
  input  logic                 rdStb,
  input  logic                 addrSel,
  input  logic [NUM_LINES-1:0] wrData,
  output cmdStb_t              stb,
  output logic                 ready
);

  seqState_t state, nextState;
  logic      needCasc, needMode;
  logic      wrAcc, isStart;

  assign wrAcc   = chipSel & wrStb;
  assign isStart = wrAcc & ~addrSel & wrData[4];
  assign ready   = (state == SEQ_RDY);

  always_comb begin
    stb       = '0;
    nextState = state;
    stb.rdAcc = chipSel & rdStb;
    if (isStart) begin
      stb.ldStart = 1'b1;
      nextState   = SEQ_BASE;
    end else if (wrAcc) begin
      unique case (state)
        SEQ_BASE: if (addrSel) begin
          stb.ldBase = 1'b1;
          nextState  = needCasc ? SEQ_CASC : (needMode ? SEQ_MODE : SEQ_RDY);
        end
        SEQ_CASC: if (addrSel) begin
          stb.ldCasc = 1'b1;
          nextState  = needMode ? SEQ_MODE : SEQ_RDY;
        end
        SEQ_MODE: if (addrSel) begin
          stb.ldMode = 1'b1;
          nextState  = SEQ_RDY;
        end
        SEQ_RDY: begin
          if (addrSel)        stb.ldMask = 1'b1;
          else if (!wrData[3]) stb.ldEoi = 1'b1;
          else                stb.ldStat = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= SEQ_IDLE;
      needCasc <= 1'b0;
      needMode <= 1'b0;
    end else begin
      state <= nextState;
      if (isStart) begin
        needCasc <= ~wrData[1];
        needMode <= wrData[0];
      end
    end
  end

  AST_START_RESTARTS: assert property (@(posedge clk) disable iff (!rstN)
    isStart |=> (state == SEQ_BASE) && !ready); // R1
  AST_CASC_EXPECTED: assert property (@(posedge clk) disable iff (!rstN)
    (state == SEQ_BASE && wrAcc && addrSel && !isStart && needCasc) |=> (state == SEQ_CASC)); // R4
  AST_MODE_COMPLETES: assert property (@(posedge clk) disable iff (!rstN)
    (state == SEQ_MODE && wrAcc && addrSel && !isStart) |=> ready); // R4

endmodule

// File: rtl/pic_cfg_dp.sv
module pic_cfg_dp
  import pic_cmd_pkg::*;
#(
  parameter int NUM_LINES = 8,
  localparam int LVL_W = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  cmdStb_t              stb,
  input  logic                 addrSel,
  input  logic [NUM_LINES-1:0] wrData,
  input  logic [NUM_LINES-1:0] irrIn,
  input  logic [NUM_LINES-1:0] isrIn,
  input  logic                 pollPending,
  input  logic [LVL_W-1:0]     pollLevel,
  output logic [NUM_LINES-1:0] rdData,
  output logic                 cfgSingle,
  output logic                 cfgInterval4,
  output logic                 cfgLevelTrig,
  output logic [2:0]           cfgVecHigh,
  output logic [NUM_LINES-1:0] cfgVecBase,
  output logic [NUM_LINES-1:0] cfgCascade,
  output logic                 cfgCpuMode,
  output logic                 cfgAutoEoi,
  output logic                 cfgMaster,
  output logic                 cfgBuffered,
  output logic                 cfgNestedSpecial,
  output logic [NUM_LINES-1:0] maskReg,
  output logic                 specialMask,
  output logic                 initStb,
  output logic                 eoiValid,
  output logic                 eoiRotate,
  output logic                 eoiSelect,
  output logic                 eoiEnd,
  output logic [LVL_W-1:0]     eoiLevel,
  output logic                 pollCommit,
  output logic [LVL_W-1:0]     pollCommitLevel
);

  localparam logic [NUM_LINES-1:0] CASC_DEFAULT = NUM_LINES'(7);

  logic readIsr;
  logic pollArmed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgSingle        <= 1'b0;
      cfgInterval4     <= 1'b0;
      cfgLevelTrig     <= 1'b0;
      cfgVecHigh       <= '0;
      cfgVecBase       <= '0;
      cfgCascade       <= CASC_DEFAULT;
      cfgCpuMode       <= 1'b0;
      cfgAutoEoi       <= 1'b0;
      cfgMaster        <= 1'b0;
      cfgBuffered      <= 1'b0;
      cfgNestedSpecial <= 1'b0;
      maskReg          <= '0;
      specialMask      <= 1'b0;
      readIsr          <= 1'b0;
      pollArmed        <= 1'b0;
      initStb          <= 1'b0;
      eoiValid         <= 1'b0;
      eoiRotate        <= 1'b0;
      eoiSelect        <= 1'b0;
      eoiEnd           <= 1'b0;
      eoiLevel         <= '0;
      pollCommit       <= 1'b0;
      pollCommitLevel  <= '0;
    end else begin
      initStb    <= stb.ldStart;
      eoiValid   <= stb.ldEoi;
      pollCommit <= 1'b0;

      if (stb.rdAcc && pollArmed) begin
        pollArmed       <= 1'b0;
        pollCommit      <= pollPending;
        pollCommitLevel <= pollLevel;
      end

      if (stb.ldStart) begin
        cfgSingle    <= wrData[1];
        cfgInterval4 <= wrData[2];
        cfgLevelTrig <= wrData[3];
        cfgVecHigh   <= wrData[7:5];
        cfgCascade   <= CASC_DEFAULT;
        maskReg      <= '0;
        specialMask  <= 1'b0;
        readIsr      <= 1'b0;
        pollArmed    <= 1'b0;
        if (!wrData[0]) begin
          cfgCpuMode       <= 1'b0;
          cfgAutoEoi       <= 1'b0;
          cfgMaster        <= 1'b0;
          cfgBuffered      <= 1'b0;
          cfgNestedSpecial <= 1'b0;
        end
      end

      if (stb.ldBase) cfgVecBase <= wrData;
      if (stb.ldCasc) cfgCascade <= wrData;
      if (stb.ldMode) begin
        cfgCpuMode       <= wrData[0];
        cfgAutoEoi       <= wrData[1];
        cfgMaster        <= wrData[2];
        cfgBuffered      <= wrData[3];
        cfgNestedSpecial <= wrData[4];
      end
      if (stb.ldMask) maskReg <= wrData;
      if (stb.ldEoi) begin
        eoiRotate <= wrData[7];
        eoiSelect <= wrData[6];
        eoiEnd    <= wrData[5];
        eoiLevel  <= wrData[LVL_W-1:0];
      end
      if (stb.ldStat) begin
        if (wrData[1]) readIsr <= wrData[0];
        if (wrData[2]) pollArmed <= 1'b1;
        if (wrData[6]) specialMask <= wrData[5];
      end
    end
  end

  always_comb begin
    rdData = '0;
    if (stb.rdAcc) begin
      if (pollArmed) begin
        rdData[NUM_LINES-1] = pollPending;
        rdData[LVL_W-1:0]   = pollLevel;
      end else if (addrSel) begin
        rdData = maskReg;
      end else begin
        rdData = readIsr ? isrIn : irrIn;
      end
    end
  end

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    stb.ldStart |=> (maskReg == '0) && (cfgCascade == CASC_DEFAULT) && !specialMask && initStb); // R2
  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    stb.ldMask |=> (maskReg == $past(wrData))); // R6
  AST_EOI_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    stb.ldEoi |=> eoiValid && (eoiLevel == $past(wrData[LVL_W-1:0]))); // R8
  AST_POLL_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rdAcc && pollArmed && !stb.ldStat) |=> !pollArmed); // R11

endmodule

// File: rtl/pic_cmd_front.sv
module pic_cmd_front
  import pic_cmd_pkg::*;
#(
  parameter int NUM_LINES = 8,
  localparam int LVL_W = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 chipSel,
  input  logic                 wrStb,
  input  logic                 rdStb,
  input  logic                 addrSel,
  input  logic [NUM_LINES-1:0] wrData,
  output logic [NUM_LINES-1:0] rdData,
  input  logic [NUM_LINES-1:0] irrIn,
  input  logic [NUM_LINES-1:0] isrIn,
  input  logic                 pollPending,
  input  logic [LVL_W-1:0]     pollLevel,
  output logic                 cfgReady,
  output logic                 cfgSingle,
  output logic                 cfgInterval4,
  output logic                 cfgLevelTrig,
  output logic [2:0]           cfgVecHigh,
  output logic [NUM_LINES-1:0] cfgVecBase,
  output logic [NUM_LINES-1:0] cfgCascade,
  output logic                 cfgCpuMode,
  output logic                 cfgAutoEoi,
  output logic                 cfgMaster,
  output logic                 cfgBuffered,
  output logic                 cfgNestedSpecial,
  output logic [NUM_LINES-1:0] maskReg,
  output logic                 specialMask,
  output logic                 initStb,
  output logic                 eoiValid,
  output logic                 eoiRotate,
  output logic                 eoiSelect,
  output logic                 eoiEnd,
  output logic [LVL_W-1:0]     eoiLevel,
  output logic                 pollCommit,
  output logic [LVL_W-1:0]     pollCommitLevel
);

  cmdStb_t stb;

  pic_seq_ctrl #(.NUM_LINES(NUM_LINES)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .chipSel (chipSel),
    .wrStb   (wrStb),
    .rdStb   (rdStb),
    .addrSel (addrSel),
    .wrData  (wrData),
    .stb     (stb),
    .ready   (cfgReady)
  );

  pic_cfg_dp #(.NUM_LINES(NUM_LINES)) uDp (
    .clk              (clk),
    .rstN             (rstN),
    .stb              (stb),
    .addrSel          (addrSel),
    .wrData           (wrData),
    .irrIn            (irrIn),
    .isrIn            (isrIn),
    .pollPending      (pollPending),
    .pollLevel        (pollLevel),
    .rdData           (rdData),
    .cfgSingle        (cfgSingle),
    .cfgInterval4     (cfgInterval4),
    .cfgLevelTrig     (cfgLevelTrig),
    .cfgVecHigh       (cfgVecHigh),
    .cfgVecBase       (cfgVecBase),
    .cfgCascade       (cfgCascade),
    .cfgCpuMode       (cfgCpuMode),
    .cfgAutoEoi       (cfgAutoEoi),
    .cfgMaster        (cfgMaster),
    .cfgBuffered      (cfgBuffered),
    .cfgNestedSpecial (cfgNestedSpecial),
    .maskReg          (maskReg),
    .specialMask      (specialMask),
    .initStb          (initStb),
    .eoiValid         (eoiValid),
    .eoiRotate        (eoiRotate),
    .eoiSelect        (eoiSelect),
    .eoiEnd           (eoiEnd),
    .eoiLevel         (eoiLevel),
    .pollCommit       (pollCommit),
    .pollCommitLevel  (pollCommitLevel)
  );

endmodule

// File: tb/tb_pic_cmd_front.sv
`timescale 1ns/1ps
module tb_pic_cmd_front;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       chipSel = 1'b0, wrStb = 1'b0, rdStb = 1'b0, addrSel = 1'b0;
  logic [7:0] wrData = '0, rdData, irrIn = 8'h3C, isrIn = 8'h81;
  logic       pollPending = 1'b0;
  logic [2:0] pollLevel = '0;
  logic       cfgReady, cfgSingle, cfgInterval4, cfgLevelTrig;
  logic [2:0] cfgVecHigh;
  logic [7:0] cfgVecBase, cfgCascade, maskReg;
  logic       cfgCpuMode, cfgAutoEoi, cfgMaster, cfgBuffered, cfgNestedSpecial;
  logic       specialMask, initStb, eoiValid, eoiRotate, eoiSelect, eoiEnd, pollCommit;
  logic [2:0] eoiLevel, pollCommitLevel;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  pic_cmd_front dut (
    .clk(clk), .rstN(rstN), .chipSel(chipSel), .wrStb(wrStb), .rdStb(rdStb),
    .addrSel(addrSel), .wrData(wrData), .rdData(rdData), .irrIn(irrIn), .isrIn(isrIn),
    .pollPending(pollPending), .pollLevel(pollLevel), .cfgReady(cfgReady),
    .cfgSingle(cfgSingle), .cfgInterval4(cfgInterval4), .cfgLevelTrig(cfgLevelTrig),
    .cfgVecHigh(cfgVecHigh), .cfgVecBase(cfgVecBase), .cfgCascade(cfgCascade),
    .cfgCpuMode(cfgCpuMode), .cfgAutoEoi(cfgAutoEoi), .cfgMaster(cfgMaster),
    .cfgBuffered(cfgBuffered), .cfgNestedSpecial(cfgNestedSpecial), .maskReg(maskReg),
    .specialMask(specialMask), .initStb(initStb), .eoiValid(eoiValid),
    .eoiRotate(eoiRotate), .eoiSelect(eoiSelect), .eoiEnd(eoiEnd), .eoiLevel(eoiLevel),
    .pollCommit(pollCommit), .pollCommitLevel(pollCommitLevel)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    chipSel = 1'b1; wrStb = 1'b1; addrSel = a; wrData = d;
    @(negedge clk);
    chipSel = 1'b0; wrStb = 1'b0; wrData = '0;
  endtask

  task automatic rd(input logic cs, input logic a, output logic [7:0] v);
    @(negedge clk);
    chipSel = cs; rdStb = 1'b1; addrSel = a;
    #1 v = rdData;
    @(negedge clk);
    chipSel = 1'b0; rdStb = 1'b0;
  endtask

  task automatic tReset();
    check("R1 reset ready", {7'b0, cfgReady}, 8'h00);
    check("R2 reset mask", maskReg, 8'h00);
    check("R12 idle rdData", rdData, 8'h00);
  endtask

  task automatic tIgnoreBeforeInit();
    wr(1'b1, 8'hFF);
    check("R7 mask before setup", maskReg, 8'h00);
    wr(1'b0, 8'h68);
    check("R7 smm before setup", {7'b0, specialMask}, 8'h00);
    wr(1'b0, 8'hE5);
    check("R7 eoi before setup", {7'b0, eoiValid}, 8'h00);
  endtask

  task automatic tCascadeInit();
    wr(1'b0, 8'hB1);
    check("R2 initStb pulse", {7'b0, initStb}, 8'h01);
    check("R1 not ready", {7'b0, cfgReady}, 8'h00);
    check("R3 vecHigh", {5'b0, cfgVecHigh}, 8'h05);
    check("R3 flags", {4'b0, cfgLevelTrig, cfgInterval4, cfgSingle, 1'b0}, 8'h00);
    wr(1'b1, 8'h20);
    check("R2 initStb one cycle", {7'b0, initStb}, 8'h00);
    check("R4 vecBase", cfgVecBase, 8'h20);
    check("R4 not ready after base", {7'b0, cfgReady}, 8'h00);
    wr(1'b1, 8'h0C);
    check("R4 cascade word", cfgCascade, 8'h0C);
    check("R4 not ready after cascade", {7'b0, cfgReady}, 8'h00);
    wr(1'b1, 8'h1F);
    check("R5 mode fields",
          {3'b0, cfgNestedSpecial, cfgBuffered, cfgMaster, cfgAutoEoi, cfgCpuMode}, 8'h1F);
    check("R4 ready", {7'b0, cfgReady}, 8'h01);
  endtask

  task automatic tMaskAccess();
    logic [7:0] v;
    wr(1'b1, 8'h5A);
    check("R6 mask load", maskReg, 8'h5A);
    rd(1'b1, 1'b1, v);
    check("R6 mask read", v, 8'h5A);
  endtask

  task automatic tStatusModes();
    logic [7:0] v;
    rd(1'b1, 1'b0, v);
    check("R12 read IRR", v, 8'h3C);
    wr(1'b0, 8'h0B);
    rd(1'b1, 1'b0, v);
    check("R9 select ISR", v, 8'h81);
    wr(1'b0, 8'h08);
    rd(1'b1, 1'b0, v);
    check("R9 RR=0 keeps ISR", v, 8'h81);
    wr(1'b0, 8'h68);
    check("R10 smm set", {7'b0, specialMask}, 8'h01);
    wr(1'b0, 8'h28);
    check("R10 ESMM=0 keeps smm", {7'b0, specialMask}, 8'h01);
    wr(1'b0, 8'h48);
    check("R10 smm clear", {7'b0, specialMask}, 8'h00);
    wr(1'b0, 8'h68);
  endtask

  task automatic tRestart();
    logic [7:0] v;
    wr(1'b0, 8'h1A);
    check("R2 restart initStb", {7'b0, initStb}, 8'h01);
    check("R2 restart mask", maskReg, 8'h00);
    check("R2 restart cascade", cfgCascade, 8'h07);
    check("R2 restart smm", {7'b0, specialMask}, 8'h00);
    check("R3 mode cleared",
          {3'b0, cfgNestedSpecial, cfgBuffered, cfgMaster, cfgAutoEoi, cfgCpuMode}, 8'h00);
    check("R3 level single", {6'b0, cfgLevelTrig, cfgSingle}, 8'h03);
    check("R1 restart not ready", {7'b0, cfgReady}, 8'h00);
    rd(1'b1, 1'b0, v);
    check("R2 status back to IRR", v, 8'h3C);
    wr(1'b1, 8'h40);
    check("R4 single no mode word ready", {7'b0, cfgReady}, 8'h01);
    check("R4 base", cfgVecBase, 8'h40);
  endtask

  task automatic tMidRestart();
    wr(1'b0, 8'h11);
    wr(1'b1, 8'h22);
    wr(1'b0, 8'h10);
    wr(1'b1, 8'h55);
    check("R1 mid restart base", cfgVecBase, 8'h55);
    check("R1 mid restart cascade kept", cfgCascade, 8'h07);
    check("R4 waits cascade", {7'b0, cfgReady}, 8'h00);
    wr(1'b0, 8'hE5);
    check("R7 eoi ignored in setup", {7'b0, eoiValid}, 8'h00);
    wr(1'b1, 8'h04);
    check("R4 cascade then ready", cfgCascade, 8'h04);
    check("R4 ready after cascade", {7'b0, cfgReady}, 8'h01);
  endtask

  task automatic tEoi();
    wr(1'b0, 8'hE5);
    check("R8 eoi pulse", {7'b0, eoiValid}, 8'h01);
    check("R8 eoi fields", {3'b0, eoiRotate, eoiSelect, eoiEnd, 2'b0}, 8'h1C);
    check("R8 eoi level", {5'b0, eoiLevel}, 8'h05);
    @(negedge clk);
    check("R8 pulse one cycle", {7'b0, eoiValid}, 8'h00);
    wr(1'b0, 8'h22);
    check("R8 plain eoi fields", {3'b0, eoiRotate, eoiSelect, eoiEnd, 2'b0}, 8'h04);
    check("R8 plain eoi level", {5'b0, eoiLevel}, 8'h02);
  endtask

  task automatic tPoll();
    logic [7:0] v;
    wr(1'b1, 8'hA5);
    pollPending = 1'b1; pollLevel = 3'd3;
    wr(1'b0, 8'h0C);
    rd(1'b1, 1'b0, v);
    check("R11 poll word", v, 8'h83);
    check("R11 commit", {4'b0, pollCommit, pollCommitLevel}, 8'h0B);
    rd(1'b1, 1'b0, v);
    check("R11 normal read after poll", v, 8'h3C);
    check("R11 commit once", {7'b0, pollCommit}, 8'h00);
    pollPending = 1'b0; pollLevel = 3'd0;
    wr(1'b0, 8'h0C);
    rd(1'b1, 1'b1, v);
    check("R11 idle poll word", v, 8'h00);
    check("R11 no commit idle", {7'b0, pollCommit}, 8'h00);
    rd(1'b1, 1'b1, v);
    check("R6 mask after poll", v, 8'hA5);
  endtask

  task automatic tChipSelRead();
    logic [7:0] v;
    pollPending = 1'b1; pollLevel = 3'd6;
    wr(1'b0, 8'h0C);
    rd(1'b0, 1'b0, v);
    check("R12 no cs read", v, 8'h00);
    check("R12 no cs commit", {7'b0, pollCommit}, 8'h00);
    rd(1'b1, 1'b0, v);
    check("R12 poll kept", v, 8'h86);
    check("R11 commit level 6", {4'b0, pollCommit, pollCommitLevel}, 8'h0E);
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tIgnoreBeforeInit();
    tCascadeInit();
    tMaskAccess();
    tStatusModes();
    tRestart();
    tMidRestart();
    tEoi();
    tPoll();
    tChipSelRead();
    summary();
  end

endmodule